// File: doc/BRIEF.md
# Flow Classification Hash Engine

This block computes the 16-bit hash that a flow-steering filter table uses to pick a hash bucket for a flow. A flow key of fourteen 32-bit words is presented together with two 32-bit hash keys, a two-bit filter-buffer size code and a mode select. Word 0 of the flow key carries the flow-type, pool and VLAN field. Words 1 to 13 are folded into a single XORed word. A key-driven shift-and-XOR pass then runs over two working words derived from the fold.

In perfect mode one pass with the bucket key gives a bucket hash that is masked according to the buffer size. In signature mode two passes run back to back. The first pass uses the bucket key and its result is masked more loosely. The second pass uses the signature key and its full 16-bit result is packed above the bucket hash in one 32-bit output word. The engine handles one key-bit pair per clock. A start pulse is accepted only while the engine is idle. A single-cycle valid pulse marks the result, and the result then holds until the next computation finishes.

Top module: `flow_hash_engine`

## Requirements
- R1: The bench defines C as the XOR of flow-key words 1..13 (word n is bits 32n+31:32n) and F as word 0. The lo working word is C with its 16-bit halves exchanged. The hi working word is C ^ F ^ (F >> 16). The hash is the low 16 bits of the accumulated result.
- R2: The first step XORs lo into the accumulator when key bit 0 is set, and hi when key bit 16 is set. Only after that step is lo replaced by lo ^ F ^ (F << 16). Then for i = 15 down to 1, key bit i adds (lo >> i) and key bit 16+i adds (hi >> i).
- R3: In perfect mode (sig_mode = 0) the bucket hash keeps 11, 12 or 13 low bits for buf_code 1, 2 or 3, and sig_word equals {16'h0000, bucket_hash}.
- R4: In signature mode (sig_mode = 1) the bucket hash keeps 13, 14 or 15 low bits for buf_code 1, 2 or 3.
- R5: In signature mode the bucket hash is computed with bkt_key and the unmasked signature hash with sig_key. sig_word holds the signature in bits 31:16 and the bucket hash in bits 15:0.
- R6: out_valid rises 17 clock edges after the edge that accepts start in perfect mode, and 34 edges after it in signature mode.
- R7: out_valid is high for exactly one cycle per accepted start, and busy is high from acceptance until that cycle.
- R8: A start pulse while busy is high is ignored. The running computation finishes at its normal time with its original inputs.
- R9: A start with buf_code 0 while idle sets cfg_err on the next edge, starts nothing and produces no out_valid. The next accepted start clears cfg_err.
- R10: bucket_hash and sig_word change only in the cycle in which out_valid is high, and otherwise keep the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to hash the presented inputs |
| flow_key | input | 448 | Flow key, word n in bits 32n+31:32n |
| bkt_key | input | 32 | Hash key for the bucket pass |
| sig_key | input | 32 | Hash key for the signature pass |
| buf_code | input | 2 | Filter buffer size code, 1 to 3 legal |
| sig_mode | input | 1 | 1 selects signature mode, 0 perfect mode |
| busy | output | 1 | Computation in progress |
| out_valid | output | 1 | Single-cycle result strobe |
| bucket_hash | output | 16 | Masked bucket hash |
| sig_word | output | 32 | Signature hash above bucket hash |
| cfg_err | output | 1 | Last start carried an illegal buffer code |

## Verification
The bench builds the engine with its default parameters: fourteen 32-bit key words and base mask widths of 10 and 12. With these values the three legal buffer codes reach every mask width from 11 to 15 bits, and the two modes give the two pass-chain lengths. Directed vectors with a single key bit isolate the fold, the word swap and the late injection of word 0. Random flow keys and hash keys then cover the full XOR network.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;
   typedef enum logic [1:0] {
      BUF_BAD  = 2'd0,
      BUF_SMALL = 2'd1,
      BUF_MID  = 2'd2,
      BUF_LARGE = 2'd3
   } buf_code_e;

   typedef enum logic {
      PH_BUCKET = 1'b0,
      PH_SIGNATURE = 1'b1
   } pass_phase_e;
endpackage

// File: rtl/fhe_fold.sv
module fhe_fold #(
   parameter int KEY_DWORDS = 14,
   parameter int WORD_W     = 32
) (
   input  logic [KEY_DWORDS*WORD_W-1:0] flow_key,
   output logic [WORD_W-1:0]            lo_o,
   output logic [WORD_W-1:0]            hi_o,
   output logic [WORD_W-1:0]            fvv_o
);
   localparam int HALF = WORD_W / 2;

   logic [WORD_W-1:0] word_s [KEY_DWORDS];
   logic [WORD_W-1:0] common;

   for (genvar d = 0; d < KEY_DWORDS; d++) begin : g_slice
      assign word_s[d] = flow_key[d*WORD_W +: WORD_W];
   end

   always_comb begin
      common = '0;
      for (int d = 1; d < KEY_DWORDS; d++) common = common ^ word_s[d];
   end

   assign fvv_o = word_s[0];
   assign lo_o  = {common[HALF-1:0], common[WORD_W-1:HALF]};
   assign hi_o  = common ^ word_s[0] ^ (word_s[0] >> HALF);
endmodule

// File: rtl/fhe_pass.sv
module fhe_pass #(
   parameter int WORD_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [WORD_W-1:0]   key_in,
   input  logic [WORD_W-1:0]   lo_in,
   input  logic [WORD_W-1:0]   hi_in,
   input  logic [WORD_W-1:0]   fvv_in,
   output logic                done,
   output logic [WORD_W/2-1:0] result
);
   localparam int HASH_W = WORD_W / 2;
   localparam int STEPS  = HASH_W;
   localparam int STEP_W = $clog2(STEPS);

   logic [WORD_W-1:0] key_q, lo_q, hi_q, fvv_q;
   logic [HASH_W-1:0] acc_q, acc_nx, term;
   logic [STEP_W-1:0] step_q, idx;
   logic              run_q;
   logic [WORD_W-1:0] lo_sh, hi_sh;
   logic [HASH_W-1:0] key_lo, key_hi;

   assign key_lo = key_q[HASH_W-1:0];
   assign key_hi = key_q[WORD_W-1:HASH_W];

   always_comb begin
      idx   = (step_q == '0) ? '0 : STEP_W'(STEPS - int'(step_q));
      lo_sh = lo_q >> idx;
      hi_sh = hi_q >> idx;
      term  = (key_lo[idx] ? lo_sh[HASH_W-1:0] : '0) ^
              (key_hi[idx] ? hi_sh[HASH_W-1:0] : '0);
      acc_nx = acc_q ^ term;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q  <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         fvv_q  <= '0;
         acc_q  <= '0;
         step_q <= '0;
         run_q  <= 1'b0;
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         if (load) begin
            key_q  <= key_in;
            lo_q   <= lo_in;
            hi_q   <= hi_in;
            fvv_q  <= fvv_in;
            acc_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b1;
         end else if (run_q) begin
            acc_q  <= acc_nx;
            step_q <= step_q + 1'b1;
            if (step_q == '0) lo_q <= lo_q ^ fvv_q ^ (fvv_q << HASH_W);
            if (step_q == STEP_W'(STEPS - 1)) begin
               run_q  <= 1'b0;
               done   <= 1'b1;
               result <= acc_nx;
            end
         end
      end
   end
endmodule

// File: rtl/flow_hash_engine.sv
module flow_hash_engine
   import flow_hash_pkg::*;
#(
   parameter int KEY_DWORDS  = 14,
   parameter int WORD_W      = 32,
   parameter int PERF_BASE_W = 10,
   parameter int SIG_BASE_W  = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [KEY_DWORDS*WORD_W-1:0] flow_key,
   input  logic [WORD_W-1:0]            bkt_key,
   input  logic [WORD_W-1:0]            sig_key,
   input  logic [1:0]                   buf_code,
   input  logic                         sig_mode,
   output logic                         busy,
   output logic                         out_valid,
   output logic [WORD_W/2-1:0]          bucket_hash,
   output logic [WORD_W-1:0]            sig_word,
   output logic                         cfg_err
);
   localparam int HASH_W = WORD_W / 2;

   if (WORD_W % 2 != 0) begin : g_bad_word
      $error("WORD_W must be even");
   end
   if (KEY_DWORDS < 2) begin : g_bad_dwords
      $error("KEY_DWORDS must be at least 2");
   end
   if (SIG_BASE_W + 3 > HASH_W || PERF_BASE_W + 3 > HASH_W) begin : g_bad_mask
      $error("mask base widths too large for the hash width");
   end

   logic [WORD_W-1:0] f_lo, f_hi, f_fvv;
   logic [WORD_W-1:0] lo0_q, hi0_q, fvv0_q, sig_key_q;
   logic              mode_q;
   buf_code_e         code_q;
   pass_phase_e       phase_q;
   logic              busy_q, valid_q, err_q;
   logic [HASH_W-1:0] bkt_q, bucket_q, mask, masked;
   logic [WORD_W-1:0] word_q;
   logic              accept, reject, p_load, p_done;
   logic [WORD_W-1:0] p_key, p_lo, p_hi, p_fvv;
   logic [HASH_W-1:0] p_res;
   int                keep_w;

   fhe_fold #(.KEY_DWORDS(KEY_DWORDS), .WORD_W(WORD_W)) i_fold (
      .flow_key(flow_key), .lo_o(f_lo), .hi_o(f_hi), .fvv_o(f_fvv));

   assign accept = start && !busy_q && (buf_code != BUF_BAD);
   assign reject = start && !busy_q && (buf_code == BUF_BAD);
   assign p_load = accept || (p_done && phase_q == PH_BUCKET && mode_q);
   assign p_key  = accept ? bkt_key : sig_key_q;
   assign p_lo   = accept ? f_lo    : lo0_q;
   assign p_hi   = accept ? f_hi    : hi0_q;
   assign p_fvv  = accept ? f_fvv   : fvv0_q;

   fhe_pass #(.WORD_W(WORD_W)) i_pass (
      .clk(clk), .rst_n(rst_n), .load(p_load), .key_in(p_key),
      .lo_in(p_lo), .hi_in(p_hi), .fvv_in(p_fvv),
      .done(p_done), .result(p_res));

   always_comb begin
      keep_w = (mode_q ? SIG_BASE_W : PERF_BASE_W) + int'(code_q);
      for (int b = 0; b < HASH_W; b++) mask[b] = (b < keep_w);
      masked = p_res & mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo0_q     <= '0;
         hi0_q     <= '0;
         fvv0_q    <= '0;
         sig_key_q <= '0;
         mode_q    <= 1'b0;
         code_q    <= BUF_BAD;
         phase_q   <= PH_BUCKET;
         busy_q    <= 1'b0;
         valid_q   <= 1'b0;
         err_q     <= 1'b0;
         bkt_q     <= '0;
         bucket_q  <= '0;
         word_q    <= '0;
      end else begin
         valid_q <= 1'b0;
         if (accept) begin
            lo0_q     <= f_lo;
            hi0_q     <= f_hi;
            fvv0_q    <= f_fvv;
            sig_key_q <= sig_key;
            mode_q    <= sig_mode;
            code_q    <= buf_code_e'(buf_code);
            phase_q   <= PH_BUCKET;
            busy_q    <= 1'b1;
            err_q     <= 1'b0;
         end else if (reject) begin
            err_q <= 1'b1;
         end
         if (p_done) begin
            if (phase_q == PH_BUCKET && mode_q) begin
               bkt_q   <= masked;
               phase_q <= PH_SIGNATURE;
            end else begin
               if (phase_q == PH_BUCKET) begin
                  bucket_q <= masked;
                  word_q   <= {{HASH_W{1'b0}}, masked};
               end else begin
                  bucket_q <= bkt_q;
                  word_q   <= {p_res, bkt_q};
               end
               phase_q <= PH_BUCKET;
               valid_q <= 1'b1;
               busy_q  <= 1'b0;
            end
         end
      end
   end

   assign busy        = busy_q;
   assign out_valid   = valid_q;
   assign bucket_hash = bucket_q;
   assign sig_word    = word_q;
   assign cfg_err     = err_q;
endmodule

// File: rtl/fhe_checker.sv
module fhe_checker #(
   parameter int WORD_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic [1:0]          buf_code,
   input logic                busy,
   input logic                out_valid,
   input logic [WORD_W/2-1:0] bucket_hash,
   input logic [WORD_W-1:0]   sig_word,
   input logic                cfg_err
);
   localparam int HASH_W = WORD_W / 2;

   assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_valid_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(busy));

   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && buf_code != 2'd0) |=> busy);

   assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> (busy || out_valid));

   assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && buf_code == 2'd0) |=> (cfg_err && !busy && !out_valid));

   assert_top_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (bucket_hash[HASH_W-1] == 1'b0));

   assert_pack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sig_word[HASH_W-1:0] == bucket_hash));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(bucket_hash) && $stable(sig_word)));
endmodule

bind flow_hash_engine fhe_checker #(.WORD_W(WORD_W)) i_fhe_checker (
   .clk(clk), .rst_n(rst_n), .start(start), .buf_code(buf_code),
   .busy(busy), .out_valid(out_valid), .bucket_hash(bucket_hash),
   .sig_word(sig_word), .cfg_err(cfg_err));

// File: tb/test_flow_hash_engine.sv
`timescale 1ns/1ps
module test_flow_hash_engine;
   localparam int KD = 14;
   localparam int KW = KD * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [KW-1:0] flow_key = '0;
   logic [31:0]   bkt_key = '0, sig_key = '0;
   logic [1:0]    buf_code = 2'd1;
   logic          sig_mode = 1'b0;
   logic          busy, out_valid, cfg_err;
   logic [15:0]   bucket_hash;
   logic [31:0]   sig_word;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   flow_hash_engine i_flow_hash_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .flow_key(flow_key),
      .bkt_key(bkt_key), .sig_key(sig_key), .buf_code(buf_code),
      .sig_mode(sig_mode), .busy(busy), .out_valid(out_valid),
      .bucket_hash(bucket_hash), .sig_word(sig_word), .cfg_err(cfg_err));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_hash(input logic [KW-1:0] fk, input logic [31:0] k);
      logic [31:0] c, f, lo, hi, t;
      logic [15:0] acc;
      c = '0;
      for (int d = 1; d < KD; d++) c ^= fk[d*32 +: 32];
      f  = fk[31:0];
      lo = {c[15:0], c[31:16]};
      hi = c ^ f ^ (f >> 16);
      acc = '0;
      if (k[0])  acc ^= lo[15:0];
      if (k[16]) acc ^= hi[15:0];
      lo = lo ^ f ^ (f << 16);
      for (int i = 15; i >= 1; i--) begin
         t = lo >> i; if (k[i])      acc ^= t[15:0];
         t = hi >> i; if (k[16 + i]) acc ^= t[15:0];
      end
      return acc;
   endfunction

   function automatic logic [15:0] ref_mask(input logic mode, input logic [1:0] code);
      int w;
      w = (mode ? 12 : 10) + int'(code);
      return 16'((32'd1 << w) - 1);
   endfunction

   // apply one request; returns latency in edges and captured outputs
   task automatic run(input logic [KW-1:0] fk, input logic [31:0] bk, input logic [31:0] sk,
                      input logic [1:0] code, input logic mode, input bit poke,
                      output int lat, output logic [15:0] bh, output logic [31:0] sw);
      @(negedge clk);
      flow_key = fk; bkt_key = bk; sig_key = sk; buf_code = code; sig_mode = mode;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      flow_key = ~fk; bkt_key = ~bk; sig_key = ~sk;
      lat = 0;
      while (!out_valid && lat < 100) begin
         if (poke && lat == 5) begin
            start = 1'b1; buf_code = 2'd3; sig_mode = ~mode;
         end else start = 1'b0;
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      bh = bucket_hash; sw = sig_word;
   endtask

   task automatic full_check(input string tag, input logic [KW-1:0] fk, input logic [31:0] bk,
                             input logic [31:0] sk, input logic [1:0] code, input logic mode,
                             input bit poke);
      int lat; logic [15:0] bh; logic [31:0] sw, exp_w; logic [15:0] exp_b;
      run(fk, bk, sk, code, mode, poke, lat, bh, sw);
      exp_b = ref_hash(fk, bk) & ref_mask(mode, code);
      exp_w = mode ? {ref_hash(fk, sk), exp_b} : {16'h0, exp_b};
      check({tag, " R3/R4 bucket"}, 32'(bh), 32'(exp_b));
      check({tag, " R5 word"}, sw, exp_w);
      check({tag, " R6 latency"}, 32'(lat), mode ? 32'd34 : 32'd17);
   endtask

   initial begin
      logic [KW-1:0] fk;
      int lat; logic [15:0] bh; logic [31:0] sw;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // reset state
      check("R7 reset busy", 32'(busy), 32'd0);
      check("R7 reset valid", 32'(out_valid), 32'd0);
      check("R9 reset err", 32'(cfg_err), 32'd0);
      check("R10 reset word", sig_word, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: swap of the common word, key bit 0
      fk = '0; fk[63:32] = 32'h12345678;
      run(fk, 32'h1, 32'h0, 2'd3, 1'b0, 1'b0, lat, bh, sw);
      check("R1 swapped lo", 32'(bh), 32'h1234);
      check("R3 perfect word", sw, 32'h0000_1234);
      check("R6 perfect latency", 32'(lat), 32'd17);

      // R1: hi word folds word 0, key bit 16, 11-bit mask
      fk = '0; fk[31:0] = 32'h0000_00FF;
      run(fk, 32'h0001_0000, 32'h0, 2'd1, 1'b0, 1'b0, lat, bh, sw);
      check("R1 hi fold", 32'(bh), 32'h00FF);

      // R2: word 0 reaches lo only after the first step
      fk = '0; fk[31:0] = 32'h0000_0002;
      run(fk, 32'h1, 32'h2, 2'd1, 1'b1, 1'b0, lat, bh, sw);
      check("R2 late inject bucket", 32'(bh), 32'h0);
      check("R2 late inject sig", sw, 32'h0001_0000);
      check("R6 signature latency", 32'(lat), 32'd34);

      // masks at all widths with all-ones inputs
      fk = '1;
      for (int c = 1; c < 4; c++) begin
         full_check("ones perfect", fk, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 2'(c), 1'b0, 1'b0);
         full_check("ones sig", fk, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'(c), 1'b1, 1'b0);
      end

      // R10: outputs hold while inputs move without start
      bh = bucket_hash; sw = sig_word;
      repeat (10) begin
         @(negedge clk);
         flow_key = ~flow_key; bkt_key = $urandom; buf_code = 2'(1 + $urandom_range(0, 2));
      end
      check("R10 hold bucket", 32'(bucket_hash), 32'(bh));
      check("R10 hold word", sig_word, sw);

      // R9: illegal buffer code
      @(negedge clk);
      buf_code = 2'd0; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R9 err set", 32'(cfg_err), 32'd1);
      check("R9 not busy", 32'(busy), 32'd0);
      begin
         int seen = 0;
         repeat (40) begin
            @(negedge clk);
            if (out_valid) seen++;
         end
         check("R9 no valid", 32'(seen), 32'd0);
      end
      check("R10 hold after reject", sig_word, sw);
      full_check("R9 clear", fk, 32'h0BAD_F00D, 32'h1357_9BDF, 2'd2, 1'b1, 1'b0);
      check("R9 err cleared", 32'(cfg_err), 32'd0);

      // R8: start while busy is ignored
      fk = {14{$urandom}};
      full_check("R8 poke perfect", fk, $urandom, $urandom, 2'd1, 1'b0, 1'b1);
      full_check("R8 poke sig", fk, $urandom, $urandom, 2'd2, 1'b1, 1'b1);

      // R7: exactly one valid pulse
      begin
         int pulses = 0;
         repeat (40) begin
            @(negedge clk);
            if (out_valid) pulses++;
         end
         check("R7 no extra pulse", 32'(pulses), 32'd0);
      end

      // random vectors
      for (int v = 0; v < 40; v++) begin
         for (int d = 0; d < KD; d++) fk[d*32 +: 32] = $urandom;
         full_check("random R1 R2", fk, $urandom, $urandom,
                    2'(1 + $urandom_range(0, 2)), 1'($urandom_range(0, 1)), 1'b0);
      end

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R6 actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule